// File: doc/BRIEF.md
# Caption Byte Pair Capture

This block takes the data bits that an upstream slicer has already recovered from one video line and turns them into a pair of caption characters. A line counter, a field flag and two framing pulses tell it where each line starts and ends. A strobe with a data bit delivers the recovered bits. Three control inputs set its behaviour: which field to decode, whether to search one line or a small window of lines, and whether capture is switched off so the display can show on-screen text instead.

At the start of a line, an eligibility check decides whether the line can carry caption data. If it can, the machine moves from `IDLE` to `GATHER` and shifts in sixteen bits, least significant bit first. The sixteenth strobe completes the capture. The two characters go out as 7 data bits each plus a parity-error flag, together with the source field, an extended-data flag and a one-cycle new-data pulse. The machine then waits in `HOLD` for the end of the line.

The transitions are:
- `IDLE→GATHER`: a line start on an eligible line.
- `GATHER→HOLD`: the sixteenth strobe arrives with no line end in the same cycle.
- `GATHER→IDLE`: capture is disabled, the line ends early, or the line end coincides with the sixteenth strobe.
- `HOLD→IDLE`: the line ends.

A parity guard watches the captured lines. It raises a shutdown state when parity keeps failing.

Top module: `cc_line_capture`

## Requirements
- R1: After reset, all character, flag and pulse outputs are 0 and the shutdown output is 0.
- R2: A line is captured only when `field_id` equals `field_sel`. A value of 0 selects field 1 and a value of 1 selects field 2.
- R3: When `wide_win` is 0, only line 21 is eligible. When `wide_win` is 1, lines 19 through 23 inclusive are eligible.
- R4: When `acq_off` is high at line start, the line is not captured. If `acq_off` rises during `GATHER`, the line is discarded and no new-data pulse follows.
- R5: Bits arrive least significant bit first. Strobes 0–7 form character A and strobes 8–15 form character B. Bit 7 of each character is an odd-parity bit, and bits 6:0 appear on the character outputs.
- R6: A character's parity-error flag is 1 exactly when the number of ones across its 8 received bits is even.
- R7: `new_data` is a single-cycle pulse in the cycle after the sixteenth strobe is sampled. In that same cycle, `field_tag` and `ext_data` are 1 when the line came from field 2 and 0 otherwise.
- R8: A line that ends before sixteen strobes produces no pulse and leaves the character outputs unchanged.
- R9: Strobes after the sixteenth on the same line are ignored.
- R10: A line end in the same cycle as the sixteenth strobe still completes the capture.
- R11: `shutdown` rises after 4 consecutive captured lines in which both characters fail parity. It stays high through lines where only one character fails. It clears on the next captured line in which both characters pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_id | input | 1 | Current field, 0 = field 1, 1 = field 2 |
| line_num | input | LINE_W | Current line number, sampled at line start |
| line_start | input | 1 | One-cycle pulse at the start of a line |
| line_end | input | 1 | One-cycle pulse at the end of a line |
| bit_vld | input | 1 | Recovered-bit strobe |
| bit_val | input | 1 | Recovered data bit |
| field_sel | input | 1 | Field to decode, 0 = field 1, 1 = field 2 |
| wide_win | input | 1 | 0 = line 21 only, 1 = lines 19 to 23 |
| acq_off | input | 1 | Disables caption capture |
| char_a | output | 7 | Data bits of the first character |
| char_b | output | 7 | Data bits of the second character |
| perr_a | output | 1 | Parity error on the first character |
| perr_b | output | 1 | Parity error on the second character |
| field_tag | output | 1 | Field of the last captured pair |
| ext_data | output | 1 | Extended-data flag, set for field 2 pairs |
| new_data | output | 1 | One-cycle pulse when a new pair is available |
| shutdown | output | 1 | Parity shutdown state |

## Verification
Two events can fall in the same clock cycle: the sixteenth bit completing a capture, and the line-end pulse that would otherwise discard a partial line. The bench drives the line end together with the final strobe. It then expects exactly one new-data pulse carrying the correct characters, and a return to idle so that the next line is captured normally. A second overlap is a disable request arriving while the line is being gathered. The bench checks that this overlap produces no pulse and leaves the previously captured characters in place.

// File: rtl/cc_cap_pkg.sv
package cc_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_HOLD   = 2'd2
    } cap_state_t;
endpackage

// File: rtl/cc_line_gate.sv
module cc_line_gate #(
    parameter int LINE_W   = 10,
    parameter int CAP_LINE = 21,
    parameter int WIN_LO   = 19,
    parameter int WIN_HI   = 23
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_id,
    input  logic              field_sel,
    input  logic              wide_win,
    input  logic              acq_off,
    output logic              eligible
);
    logic in_line;

    always_comb begin
        if (wide_win) begin
            in_line = (line_num >= LINE_W'(WIN_LO)) && (line_num <= LINE_W'(WIN_HI));
        end else begin
            in_line = (line_num == LINE_W'(CAP_LINE));
        end
        eligible = in_line && (field_id == field_sel) && !acq_off;
    end
endmodule

// File: rtl/cc_bit_assembler.sv
module cc_bit_assembler #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic                  at_last,
    output logic [2*BYTE_W-1:0]   word_next
);
    localparam int TOTAL = 2 * BYTE_W;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [TOTAL-1:0] shreg;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_en && (cnt < CW'(TOTAL))) begin
            shreg <= {bit_in, shreg[TOTAL-1:1]};
            cnt   <= cnt + 1'b1;
        end
    end

    always_comb begin
        word_next = {bit_in, shreg[TOTAL-1:1]};
        at_last   = (cnt == CW'(TOTAL - 1));
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TOTAL));
endmodule

// File: rtl/cc_parity_guard.sv
module cc_parity_guard #(
    parameter int SHUT_LINES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic bad_a,
    input  logic bad_b,
    output logic shutdown
);
    localparam int RW = $clog2(SHUT_LINES + 1);

    logic [RW-1:0] run_len;
    logic          shut_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            shut_q  <= 1'b0;
        end else if (upd) begin
            if (bad_a && bad_b) begin
                if (run_len != RW'(SHUT_LINES)) begin
                    run_len <= run_len + 1'b1;
                end
                if (run_len == RW'(SHUT_LINES - 1)) begin
                    shut_q <= 1'b1;
                end
            end else begin
                run_len <= '0;
                if (!bad_a && !bad_b) begin
                    shut_q <= 1'b0;
                end
            end
        end
    end

    assign shutdown = shut_q;

    // R11
    shut_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> $past(upd && bad_a && bad_b));

    // R11
    shut_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !bad_a && !bad_b) |=> !shutdown);
endmodule

// File: rtl/cc_line_capture.sv
module cc_line_capture
    import cc_cap_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int BYTE_W     = 8,
    parameter int CAP_LINE   = 21,
    parameter int WIN_LO     = 19,
    parameter int WIN_HI     = 23,
    parameter int SHUT_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_id,
    input  logic [LINE_W-1:0] line_num,
    input  logic              line_start,
    input  logic              line_end,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              field_sel,
    input  logic              wide_win,
    input  logic              acq_off,
    output logic [BYTE_W-2:0] char_a,
    output logic [BYTE_W-2:0] char_b,
    output logic              perr_a,
    output logic              perr_b,
    output logic              field_tag,
    output logic              ext_data,
    output logic              new_data,
    output logic              shutdown
);
    localparam int TOTAL = 2 * BYTE_W;

    cap_state_t        st, nxt;
    logic              gate_ok;
    logic              clr_asm, shift_en, cap;
    logic              at_last;
    logic [TOTAL-1:0]  word_next;
    logic              line_field;
    logic              bad_a_n, bad_b_n;

    cc_line_gate #(
        .LINE_W(LINE_W), .CAP_LINE(CAP_LINE), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) gate_i (
        .line_num(line_num), .field_id(field_id), .field_sel(field_sel),
        .wide_win(wide_win), .acq_off(acq_off), .eligible(gate_ok)
    );

    cc_bit_assembler #(.BYTE_W(BYTE_W)) asm_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_asm), .shift_en(shift_en),
        .bit_in(bit_val), .at_last(at_last), .word_next(word_next)
    );

    assign bad_a_n = ~(^word_next[BYTE_W-1:0]);
    assign bad_b_n = ~(^word_next[TOTAL-1:BYTE_W]);

    cc_parity_guard #(.SHUT_LINES(SHUT_LINES)) guard_i (
        .clk(clk), .rst_n(rst_n), .upd(cap), .bad_a(bad_a_n), .bad_b(bad_b_n),
        .shutdown(shutdown)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state and control
    always_comb begin
        nxt      = st;
        clr_asm  = 1'b0;
        shift_en = 1'b0;
        cap      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                clr_asm = 1'b1;
                if (line_start && gate_ok) nxt = ST_GATHER;
            end
            ST_GATHER: begin
                if (acq_off) begin
                    nxt = ST_IDLE;
                end else begin
                    shift_en = bit_vld;
                    if (bit_vld && at_last) begin
                        cap = 1'b1;
                        nxt = line_end ? ST_IDLE : ST_HOLD;
                    end else if (line_end) begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (line_end) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_field <= 1'b0;
            char_a     <= '0;
            char_b     <= '0;
            perr_a     <= 1'b0;
            perr_b     <= 1'b0;
            field_tag  <= 1'b0;
            ext_data   <= 1'b0;
            new_data   <= 1'b0;
        end else begin
            new_data <= cap;
            if (st == ST_IDLE && line_start) line_field <= field_id;
            if (cap) begin
                char_a    <= word_next[BYTE_W-2:0];
                char_b    <= word_next[TOTAL-2:BYTE_W];
                perr_a    <= bad_a_n;
                perr_b    <= bad_b_n;
                field_tag <= line_field;
                ext_data  <= line_field;
            end
        end
    end

    // R4
    acq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_off |=> !new_data);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |=> !new_data);
endmodule

// File: tb/cc_line_capture_tb.sv
`timescale 1ns/1ps
module cc_line_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       field_id, line_start, line_end, bit_vld, bit_val;
    logic       field_sel, wide_win, acq_off;
    logic [9:0] line_num;
    logic [6:0] char_a, char_b;
    logic       perr_a, perr_b, field_tag, ext_data, new_data, shutdown;

    int n_chk  = 0;
    int n_fail = 0;
    int nd_cnt = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cc_line_capture dut_i (
        .clk(clk), .rst_n(rst_n), .field_id(field_id), .line_num(line_num),
        .line_start(line_start), .line_end(line_end), .bit_vld(bit_vld),
        .bit_val(bit_val), .field_sel(field_sel), .wide_win(wide_win),
        .acq_off(acq_off), .char_a(char_a), .char_b(char_b), .perr_a(perr_a),
        .perr_b(perr_b), .field_tag(field_tag), .ext_data(ext_data),
        .new_data(new_data), .shutdown(shutdown)
    );

    always @(negedge clk) if (rst_n && new_data) nd_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic [6:0] d, input bit good);
        return good ? {~^d, d} : {^d, d};
    endfunction

    task automatic run_line(input logic f, input int ln, input logic [7:0] a,
                            input logic [7:0] b, input int nbits,
                            input bit end_last, input int kill_at);
        @(negedge clk);
        field_id = f; line_num = 10'(ln); line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            bit_vld = 1'b1;
            bit_val = (i < 8) ? a[i] : ((i < 16) ? b[i-8] : 1'b1);
            if (i == kill_at) acq_off = 1'b1;
            if (end_last && i == nbits - 1) line_end = 1'b1;
            @(negedge clk);
            line_end = 1'b0;
        end
        bit_vld = 1'b0;
        if (kill_at >= 0) acq_off = 1'b0;
        if (!end_last) begin
            line_end = 1'b1;
            @(negedge clk);
            line_end = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic expect_pair(input string tag, input int base, input logic [6:0] ea,
                               input logic [6:0] eb, input logic f);
        chk(nd_cnt == base + 1, {tag, " pulse count"}, nd_cnt, base + 1);
        chk(char_a == ea, {tag, " char_a"}, char_a, ea);
        chk(char_b == eb, {tag, " char_b"}, char_b, eb);
        chk(field_tag == f && ext_data == f, {tag, " field/ext"}, {field_tag, ext_data}, {f, f});
    endtask

    task automatic expect_none(input string tag, input int base, input logic [6:0] ea);
        chk(nd_cnt == base, {tag, " no pulse"}, nd_cnt, base);
        chk(char_a == ea, {tag, " char_a kept"}, char_a, ea);
    endtask

    task automatic t_reset();
        chk(char_a == 0 && char_b == 0, "R1 chars zero", {char_a, char_b}, 0);
        chk(!perr_a && !perr_b && !field_tag && !ext_data, "R1 flags zero",
            {perr_a, perr_b, field_tag, ext_data}, 0);
        chk(!new_data && !shutdown, "R1 pulse/shutdown zero", {new_data, shutdown}, 0);
    endtask

    task automatic t_basic();
        int b = nd_cnt;
        run_line(1'b0, 21, mk(7'h41, 1), mk(7'h2C, 1), 16, 0, -1);
        expect_pair("R5 field1 line21", b, 7'h41, 7'h2C, 1'b0);
        chk(!perr_a && !perr_b, "R6 good parity", {perr_a, perr_b}, 0);
    endtask

    task automatic t_field();
        int b;
        field_sel = 1'b1;
        b = nd_cnt;
        run_line(1'b1, 21, mk(7'h15, 1), mk(7'h6A, 1), 16, 0, -1);
        expect_pair("R7 field2 capture", b, 7'h15, 7'h6A, 1'b1);
        b = nd_cnt;
        run_line(1'b0, 21, mk(7'h33, 1), mk(7'h33, 1), 16, 0, -1);
        expect_none("R2 field mismatch", b, 7'h15);
        field_sel = 1'b0;
    endtask

    task automatic t_window();
        int b = nd_cnt;
        run_line(1'b0, 20, mk(7'h01, 1), mk(7'h02, 1), 16, 0, -1);
        expect_none("R3 narrow line20", b, 7'h15);
        wide_win = 1'b1;
        b = nd_cnt;
        run_line(1'b0, 19, mk(7'h11, 1), mk(7'h12, 1), 16, 0, -1);
        expect_pair("R3 wide line19", b, 7'h11, 7'h12, 1'b0);
        b = nd_cnt;
        run_line(1'b0, 23, mk(7'h23, 1), mk(7'h24, 1), 16, 0, -1);
        expect_pair("R3 wide line23", b, 7'h23, 7'h24, 1'b0);
        b = nd_cnt;
        run_line(1'b0, 24, mk(7'h7F, 1), mk(7'h7E, 1), 16, 0, -1);
        expect_none("R3 wide line24", b, 7'h23);
        wide_win = 1'b0;
    endtask

    task automatic t_acq_off();
        int b = nd_cnt;
        acq_off = 1'b1;
        run_line(1'b0, 21, mk(7'h55, 1), mk(7'h56, 1), 16, 0, -1);
        acq_off = 1'b0;
        expect_none("R4 disabled at start", b, 7'h23);
        b = nd_cnt;
        run_line(1'b0, 21, mk(7'h57, 1), mk(7'h58, 1), 16, 0, 9);
        expect_none("R4 disabled mid-line", b, 7'h23);
    endtask

    task automatic t_parity();
        int b = nd_cnt;
        run_line(1'b0, 21, mk(7'h4D, 0), mk(7'h20, 1), 16, 0, -1);
        expect_pair("R6 bad first", b, 7'h4D, 7'h20, 1'b0);
        chk(perr_a && !perr_b, "R6 flags first bad", {perr_a, perr_b}, 2'b10);
        b = nd_cnt;
        run_line(1'b0, 21, mk(7'h00, 1), mk(7'h7F, 0), 16, 0, -1);
        chk(!perr_a && perr_b, "R6 flags second bad", {perr_a, perr_b}, 2'b01);
        chk(char_a == 7'h00 && char_b == 7'h7F, "R5 extreme values", {char_a, char_b}, {7'h00, 7'h7F});
    endtask

    task automatic t_short();
        int b = nd_cnt;
        run_line(1'b0, 21, mk(7'h3C, 1), mk(7'h3D, 1), 10, 0, -1);
        expect_none("R8 short line", b, 7'h00);
    endtask

    task automatic t_extra();
        int b = nd_cnt;
        run_line(1'b0, 21, mk(7'h2A, 1), mk(7'h54, 1), 22, 0, -1);
        expect_pair("R9 extra strobes", b, 7'h2A, 7'h54, 1'b0);
    endtask

    task automatic t_same_cycle();
        int b = nd_cnt;
        run_line(1'b0, 21, mk(7'h61, 1), mk(7'h62, 1), 16, 1, -1);
        expect_pair("R10 end with last bit", b, 7'h61, 7'h62, 1'b0);
        b = nd_cnt;
        run_line(1'b0, 21, mk(7'h63, 1), mk(7'h64, 1), 16, 0, -1);
        expect_pair("R10 next line after", b, 7'h63, 7'h64, 1'b0);
    endtask

    task automatic t_shutdown();
        for (int k = 0; k < 3; k++) run_line(1'b0, 21, mk(7'h10, 0), mk(7'h11, 0), 16, 0, -1);
        chk(!shutdown, "R11 three bad lines", shutdown, 0);
        run_line(1'b0, 21, mk(7'h10, 0), mk(7'h11, 0), 16, 0, -1);
        chk(shutdown, "R11 fourth bad line", shutdown, 1);
        run_line(1'b0, 21, mk(7'h10, 0), mk(7'h11, 1), 16, 0, -1);
        chk(shutdown, "R11 one bad keeps", shutdown, 1);
        run_line(1'b0, 21, mk(7'h10, 1), mk(7'h11, 1), 16, 0, -1);
        chk(!shutdown, "R11 good line releases", shutdown, 0);
        for (int k = 0; k < 3; k++) run_line(1'b0, 21, mk(7'h10, 0), mk(7'h11, 0), 16, 0, -1);
        run_line(1'b0, 21, mk(7'h10, 1), mk(7'h11, 0), 16, 0, -1);
        run_line(1'b0, 21, mk(7'h10, 0), mk(7'h11, 0), 16, 0, -1);
        chk(!shutdown, "R11 run broken", shutdown, 0);
    endtask

    initial begin
        rst_n = 1'b0; field_id = 0; line_num = '0; line_start = 0; line_end = 0;
        bit_vld = 0; bit_val = 0; field_sel = 0; wide_win = 0; acq_off = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_field();
        t_window();
        t_acq_off();
        t_parity();
        t_short();
        t_extra();
        t_same_cycle();
        t_shutdown();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule